// File: doc/BRIEF.md
# Stack Processor Instruction Sequencer

This block is the control core of a 16-bit processor with two stacks. Each cycle in its fetch state it reads one instruction word from a single-ported memory at the program counter. It then decodes the word as a literal push, an unconditional branch, a branch taken on a zero flag, a subroutine call, or a datapath operation. It owns the program counter, the top-of-stack register T and the two stack pointers. It drives write strobes, pointers and data toward stack memories that sit outside it. It hands the datapath operation's source-select field to an external next-T multiplexer and takes that multiplexer's result back.

Instructions that touch data memory or I/O space take a second cycle. The instruction word is held in a register, the memory port is given to the data access, and every architectural update happens at the end of that second cycle. All other instructions complete in the cycle that fetched them. Memory and I/O addresses are word addresses: T shifted right by one, so the low byte-address bit is ignored.

The memory and I/O ports are plain strobed ports with read data returned in the same cycle. They have no back-pressure: the attached memory must answer every access in the cycle it is issued.

Top module: `stack_seq_core`

## Requirements
- R1: An instruction with bit 15 set loads T with its bits 14:0, zero-extended. It raises the data pointer by one, writes the old T to the data stack at the new pointer, and advances the PC by one.
- R2: Bits 15:13 = 000 load the PC with bits 12:0, zero-extended, and leave T and both pointers unchanged.
- R3: Bits 15:13 = 001 pop the flag: T takes the data stack output and the data pointer drops by one. The PC takes the zero-extended target when the popped T was zero, and PC+1 otherwise.
- R4: Bits 15:13 = 010 write the byte address of the next instruction ((PC+1) shifted left by one) to the return stack at return pointer + 1. They raise the return pointer by one and load the PC with the target, all in one cycle.
- R5: Bits 15:13 = 011 select a datapath operation. T takes the external multiplexer result selected by bits 11:8. Bit 7 writes T to the data stack at data pointer + adjust, and bit 6 writes T to the return stack at return pointer + adjust. Bits 1:0 and bits 3:2 are two's-complement adjusts added to the data and return pointers.
- R6: In a datapath operation, bit 12 set loads the PC from bits 15:1 of the return stack output instead of PC+1.
- R7: A datapath operation with bits 11:8 = 1100 takes two cycles. The PC holds during the second cycle, and T is loaded with the word read at address T[15:1].
- R8: A datapath operation with bit 5 set takes two cycles. In the second cycle the memory port carries a write of the data stack output to word address T[15:1], and no instruction fetch takes place.
- R9: A datapath operation with bit 4 set moves its load or store from the memory port to the I/O port, and the memory port is idle in that second cycle.
- R10: After reset the PC, T and both stack pointers are zero and the sequencer is in its fetch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 15 | Memory word address (PC on fetch, T[15:1] on data access) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, same cycle |
| io_addr | output | 15 | I/O word address |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 16 | I/O write data |
| io_rdata | input | 16 | I/O read data, same cycle |
| ds_n | input | 16 | Data stack read word at the data pointer |
| ds_we | output | 1 | Data stack write enable |
| ds_wptr | output | SP_W | Data stack write pointer |
| ds_wdata | output | 16 | Data stack write data |
| rs_r | input | 16 | Return stack read word at the return pointer |
| rs_we | output | 1 | Return stack write enable |
| rs_wptr | output | SP_W | Return stack write pointer |
| rs_wdata | output | 16 | Return stack write data |
| tmux_sel | output | 4 | Source select for the external next-T multiplexer |
| alu_t | input | 16 | Result of the external next-T multiplexer |
| pc_o | output | 15 | Program counter |
| t_o | output | 16 | Top-of-stack register |
| dptr_o | output | SP_W | Data stack pointer |
| rptr_o | output | SP_W | Return stack pointer |

## Verification
The assertions assume that memory read data is valid in the same cycle as its address. They also assume that the instruction word seen in a fetch cycle is the one the cycle-accurate checks relate to the next state. Neither the memory nor the I/O port can stall. The stimulus respects these assumptions with a bench memory and I/O model that answer combinationally and accept writes at the clock edge. The program never drives a stack pointer below zero, so pointer values stay unambiguous. It also never sets a load and a store in the same instruction, which would need two accesses to the single port.

// File: rtl/seqcore_pkg.sv
package seqcore_pkg;
  localparam int WORD_W = 16;
  localparam int PC_W   = WORD_W - 1;
  localparam int TGT_W  = WORD_W - 3;
  localparam int SEL_W  = 4;

  localparam logic [SEL_W-1:0] SEL_LOAD = 4'd12;

  typedef enum logic { ST_FETCH, ST_DATA } seq_state_e;

  typedef enum logic [1:0] {
    CL_JUMP = 2'b00,
    CL_JZ   = 2'b01,
    CL_CALL = 2'b10,
    CL_ALU  = 2'b11
  } op_class_e;

  typedef struct packed {
    logic             is_lit;
    op_class_e        cls;
    logic             ret;
    logic [SEL_W-1:0] tsel;
    logic             t_to_ds;
    logic             t_to_rs;
    logic             store;
    logic             io;
    logic [1:0]       radj;
    logic [1:0]       dadj;
    logic [TGT_W-1:0] target;
    logic [PC_W-1:0]  litval;
  } dec_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seqcore_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output dec_t              dec,
  output logic              needs_data,
  output logic              is_load
);
  always_comb begin
    dec.is_lit  = instr[15];
    dec.cls     = op_class_e'(instr[14:13]);
    dec.ret     = instr[12];
    dec.tsel    = instr[11:8];
    dec.t_to_ds = instr[7];
    dec.t_to_rs = instr[6];
    dec.store   = instr[5];
    dec.io      = instr[4];
    dec.radj    = instr[3:2];
    dec.dadj    = instr[1:0];
    dec.target  = instr[TGT_W-1:0];
    dec.litval  = instr[PC_W-1:0];
  end

  logic alu_op;
  assign alu_op     = !dec.is_lit && (dec.cls == CL_ALU);
  assign is_load    = alu_op && (dec.tsel == SEL_LOAD);
  assign needs_data = alu_op && (is_load || dec.store);
endmodule

// File: rtl/seq_stack_ptr.sv
module seq_stack_ptr #(
  parameter int SP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      adj,
  output logic [SP_W-1:0] ptr,
  output logic [SP_W-1:0] ptr_next
);
  logic [SP_W-1:0] adj_ext;
  assign adj_ext  = {{(SP_W-2){adj[1]}}, adj};
  assign ptr_next = ptr + adj_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr <= '0;
    else if (en) ptr <= ptr_next;
  end
endmodule

// File: rtl/stack_seq_core.sv
module stack_seq_core
  import seqcore_pkg::*;
#(
  parameter int SP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [PC_W-1:0]      mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic [PC_W-1:0]      io_addr,
  output logic                 io_rd,
  output logic                 io_wr,
  output logic [WORD_W-1:0]    io_wdata,
  input  logic [WORD_W-1:0]    io_rdata,
  input  logic [WORD_W-1:0]    ds_n,
  output logic                 ds_we,
  output logic [SP_W-1:0]      ds_wptr,
  output logic [WORD_W-1:0]    ds_wdata,
  input  logic [WORD_W-1:0]    rs_r,
  output logic                 rs_we,
  output logic [SP_W-1:0]      rs_wptr,
  output logic [WORD_W-1:0]    rs_wdata,
  output logic [SEL_W-1:0]     tmux_sel,
  input  logic [WORD_W-1:0]    alu_t,
  output logic [PC_W-1:0]      pc_o,
  output logic [WORD_W-1:0]    t_o,
  output logic [SP_W-1:0]      dptr_o,
  output logic [SP_W-1:0]      rptr_o
);
  seq_state_e        state;
  logic [WORD_W-1:0] ir;
  logic [WORD_W-1:0] instr;
  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] t_q;
  dec_t              dec;
  logic              needs_data, is_load, busy, exec;
  logic              op_alu, op_jz, op_call, op_jump;
  logic [1:0]        d_adj, r_adj;
  logic [SP_W-1:0]   d_next, r_next;
  logic [PC_W-1:0]   pc_inc;

  assign busy  = (state == ST_DATA);
  assign instr = busy ? ir : mem_rdata;

  seq_decode u_dec (
    .instr      (instr),
    .dec        (dec),
    .needs_data (needs_data),
    .is_load    (is_load)
  );

  assign op_alu  = !dec.is_lit && (dec.cls == CL_ALU);
  assign op_jz   = !dec.is_lit && (dec.cls == CL_JZ);
  assign op_call = !dec.is_lit && (dec.cls == CL_CALL);
  assign op_jump = !dec.is_lit && (dec.cls == CL_JUMP);
  assign exec    = busy || !needs_data;
  assign pc_inc  = pc + PC_W'(1);

  always_comb begin
    d_adj = 2'b00;
    r_adj = 2'b00;
    if (dec.is_lit)   d_adj = 2'b01;
    else if (op_jz)   d_adj = 2'b11;
    else if (op_call) r_adj = 2'b01;
    else if (op_alu) begin
      d_adj = dec.dadj;
      r_adj = dec.radj;
    end
  end

  seq_stack_ptr #(.SP_W(SP_W)) u_dptr (
    .clk(clk), .rst_n(rst_n), .en(exec), .adj(d_adj),
    .ptr(dptr_o), .ptr_next(d_next)
  );

  seq_stack_ptr #(.SP_W(SP_W)) u_rptr (
    .clk(clk), .rst_n(rst_n), .en(exec), .adj(r_adj),
    .ptr(rptr_o), .ptr_next(r_next)
  );

  // Stack write side
  assign ds_we    = exec && (dec.is_lit || (op_alu && dec.t_to_ds));
  assign ds_wptr  = d_next;
  assign ds_wdata = t_q;
  assign rs_we    = exec && (op_call || (op_alu && dec.t_to_rs));
  assign rs_wptr  = r_next;
  assign rs_wdata = op_call ? {pc_inc, 1'b0} : t_q;
  assign tmux_sel = dec.tsel;

  // Single memory port: fetch unless a data access owns the cycle
  assign mem_addr  = busy ? t_q[WORD_W-1:1] : pc;
  assign mem_rd    = busy ? (is_load && !dec.io) : 1'b1;
  assign mem_wr    = busy && dec.store && !dec.io;
  assign mem_wdata = ds_n;
  assign io_addr   = t_q[WORD_W-1:1];
  assign io_rd     = busy && is_load && dec.io;
  assign io_wr     = busy && dec.store && dec.io;
  assign io_wdata  = ds_n;

  logic [WORD_W-1:0] t_next;
  logic [PC_W-1:0]   pc_next;

  always_comb begin
    t_next  = t_q;
    pc_next = pc_inc;
    if (dec.is_lit) begin
      t_next = {1'b0, dec.litval};
    end else begin
      unique case (dec.cls)
        CL_JUMP: pc_next = {{(PC_W-TGT_W){1'b0}}, dec.target};
        CL_CALL: pc_next = {{(PC_W-TGT_W){1'b0}}, dec.target};
        CL_JZ: begin
          t_next = ds_n;
          if (t_q == '0) pc_next = {{(PC_W-TGT_W){1'b0}}, dec.target};
        end
        CL_ALU: begin
          if (is_load) t_next = dec.io ? io_rdata : mem_rdata;
          else         t_next = alu_t;
          if (dec.ret) pc_next = rs_r[WORD_W-1:1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      ir    <= '0;
      pc    <= '0;
      t_q   <= '0;
    end else begin
      if (!busy && needs_data) begin
        state <= ST_DATA;
        ir    <= mem_rdata;
      end else begin
        state <= ST_FETCH;
      end
      if (exec) begin
        pc  <= pc_next;
        t_q <= t_next;
      end
    end
  end

  assign pc_o = pc;
  assign t_o  = t_q;

  logic unused_ok;
  assign unused_ok = op_jump;
endmodule

// File: rtl/seq_core_checker.sv
module seq_core_checker #(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [14:0]     mem_addr,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [15:0]     mem_rdata,
  input logic            io_rd,
  input logic            io_wr,
  input logic [14:0]     pc_o,
  input logic [15:0]     t_o,
  input logic [SP_W-1:0] dptr_o,
  input logic [SP_W-1:0] rptr_o
);
  a_r10_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (pc_o == '0 && t_o == '0 && dptr_o == '0 && rptr_o == '0 && !busy));

  a_r1_literal_push: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mem_rdata[15]) |=>
      (t_o == {1'b0, $past(mem_rdata[14:0])}) && (dptr_o == $past(dptr_o) + SP_W'(1)));

  a_r4_call_push: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mem_rdata[15:13] == 3'b010) |=>
      (rptr_o == $past(rptr_o) + SP_W'(1)) && (pc_o == {2'b00, $past(mem_rdata[12:0])}));

  a_r7_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(pc_o));

  a_r8_fetch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_rd && !mem_wr && !io_rd && !io_wr && mem_addr == pc_o));

  a_r9_mem_idle_on_io: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (io_rd || io_wr)) |-> (!mem_rd && !mem_wr));
endmodule

bind stack_seq_core seq_core_checker #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
  .io_rd(io_rd), .io_wr(io_wr), .pc_o(pc_o), .t_o(t_o),
  .dptr_o(dptr_o), .rptr_o(rptr_o)
);

// File: tb/tb_stack_seq_core.sv
module tb_stack_seq_core;
  localparam int SP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [14:0] mem_addr, io_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, ds_we, rs_we;
  logic [15:0] mem_wdata, mem_rdata, io_wdata, io_rdata;
  logic [15:0] ds_n, ds_wdata, rs_r, rs_wdata, alu_t, t_o;
  logic [SP_W-1:0] ds_wptr, rs_wptr, dptr_o, rptr_o;
  logic [3:0]  tmux_sel;
  logic [14:0] pc_o;

  logic [15:0] mem [32];
  logic [15:0] dstk [16];
  logic [15:0] rstk [16];
  logic [14:0] io_log_addr;
  logic [15:0] io_log_data;

  stack_seq_core #(.SP_W(SP_W)) dut (.*);

  assign mem_rdata = mem[mem_addr[4:0]];
  assign io_rdata  = 16'hA000 | {1'b0, io_addr};
  assign ds_n      = dstk[dptr_o[3:0]];
  assign rs_r      = rstk[rptr_o[3:0]];

  // external next-T multiplexer model
  always_comb begin
    case (tmux_sel)
      4'd0:  alu_t = t_o;
      4'd1:  alu_t = ds_n;
      4'd2:  alu_t = t_o + ds_n;
      4'd3:  alu_t = t_o & ds_n;
      4'd4:  alu_t = t_o | ds_n;
      4'd5:  alu_t = t_o ^ ds_n;
      4'd6:  alu_t = ~t_o;
      4'd7:  alu_t = {16{ds_n == t_o}};
      4'd8:  alu_t = {16{$signed(ds_n) < $signed(t_o)}};
      4'd9:  alu_t = ds_n >> t_o[3:0];
      4'd10: alu_t = ds_n - t_o;
      4'd11: alu_t = rs_r;
      4'd13: alu_t = ds_n << t_o[3:0];
      4'd14: alu_t = {rptr_o, dptr_o};
      4'd15: alu_t = {16{ds_n < t_o}};
      default: alu_t = 16'h0;
    endcase
  end

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[4:0]] <= mem_wdata;
    if (ds_we)  dstk[ds_wptr[3:0]] <= ds_wdata;
    if (rs_we)  rstk[rs_wptr[3:0]] <= rs_wdata;
    if (io_wr) begin
      io_log_addr <= io_addr;
      io_log_data <= io_wdata;
    end
  end

  typedef struct {
    logic [14:0] pc;
    logic [15:0] t;
    logic [7:0]  d;
    logic [7:0]  r;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  task automatic push_exp(input logic [14:0] pc, input logic [15:0] t,
                          input logic [7:0] d, input logic [7:0] r, input string tag);
    exp_t e;
    e.pc = pc; e.t = t; e.d = d; e.r = r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: one expected state per cycle
  initial begin
    wait (rst_n === 1'b1);
    while (q.size() > 0) begin
      exp_t e;
      @(negedge clk);
      e = q.pop_front();
      chk(e.tag, "pc",   {17'b0, pc_o},  {17'b0, e.pc});
      chk(e.tag, "t",    {16'b0, t_o},   {16'b0, e.t});
      chk(e.tag, "dptr", {24'b0, dptr_o}, {24'b0, e.d});
      chk(e.tag, "rptr", {24'b0, rptr_o}, {24'b0, e.r});
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 16; i++) begin dstk[i] = 16'h0; rstk[i] = 16'h0; end
    io_log_addr = '0;
    io_log_data = '0;
    mem[0]  = 16'h8005; mem[1]  = 16'h8003; mem[2]  = 16'h6203; mem[3]  = 16'h400A;
    mem[4]  = 16'hFFFF; mem[5]  = 16'h6147; mem[6]  = 16'h6B8D; mem[7]  = 16'h0007;
    mem[10] = 16'h803C; mem[11] = 16'h6123; mem[12] = 16'h803C; mem[13] = 16'h6C00;
    mem[14] = 16'h6133; mem[15] = 16'h6C10; mem[16] = 16'h2014; mem[17] = 16'h8000;
    mem[18] = 16'h2014; mem[20] = 16'h700C;

    // driver: expected state after each cycle
    push_exp(15'd0,  16'h0000, 8'd0, 8'd0, "R10 reset");
    push_exp(15'd1,  16'h0005, 8'd1, 8'd0, "R1 literal");
    push_exp(15'd2,  16'h0003, 8'd2, 8'd0, "R1 literal");
    push_exp(15'd3,  16'h0008, 8'd1, 8'd0, "R5 add");
    push_exp(15'd10, 16'h0008, 8'd1, 8'd1, "R4 call");
    push_exp(15'd11, 16'h003C, 8'd2, 8'd1, "R1 literal");
    push_exp(15'd11, 16'h003C, 8'd2, 8'd1, "R8 store hold");
    push_exp(15'd12, 16'h0008, 8'd1, 8'd1, "R8 store done");
    push_exp(15'd13, 16'h003C, 8'd2, 8'd1, "R1 literal");
    push_exp(15'd13, 16'h003C, 8'd2, 8'd1, "R7 load hold");
    push_exp(15'd14, 16'h0008, 8'd2, 8'd1, "R7 load done");
    push_exp(15'd14, 16'h0008, 8'd2, 8'd1, "R9 io store hold");
    push_exp(15'd15, 16'h0008, 8'd1, 8'd1, "R9 io store done");
    push_exp(15'd15, 16'h0008, 8'd1, 8'd1, "R9 io load hold");
    push_exp(15'd16, 16'hA004, 8'd1, 8'd1, "R9 io load done");
    push_exp(15'd17, 16'h0000, 8'd0, 8'd1, "R3 flag nonzero");
    push_exp(15'd18, 16'h0000, 8'd1, 8'd1, "R1 literal zero");
    push_exp(15'd20, 16'h0000, 8'd0, 8'd1, "R3 flag zero");
    push_exp(15'd4,  16'h0000, 8'd0, 8'd0, "R6 return");
    push_exp(15'd5,  16'h7FFF, 8'd1, 8'd0, "R1 max literal");
    push_exp(15'd6,  16'h0000, 8'd0, 8'd1, "R5 to rstack");
    push_exp(15'd7,  16'h7FFF, 8'd1, 8'd0, "R5 from rstack");
    push_exp(15'd7,  16'h7FFF, 8'd1, 8'd0, "R2 jump");
    push_exp(15'd7,  16'h7FFF, 8'd1, 8'd0, "R2 jump");

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int c = 0; c < 1000; c++) begin
      if (done) break;
      @(posedge clk);
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0 pending", q.size());
    end
    @(negedge clk);
    chk("R8 store data", "mem[30]", {16'b0, mem[30]}, 32'h8);
    chk("R9 io write", "io_addr", {17'b0, io_log_addr}, 32'h4);
    chk("R9 io write", "io_data", {16'b0, io_log_data}, 32'h8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule